// File: doc/BRIEF.md
# Bit-Enabled Scaling-Free Rotation Pipeline

This block rotates a 16-bit two's-complement vector (x, y) clockwise by a small folded angle between 0 and pi/8. The pipeline is fully unrolled. Each elementary section turns the vector by a fixed small angle of about 2^-i radians. The section's arithmetic keeps the vector length to first order, so no scale factor builds up along the chain. Rotation always goes in one direction. Each bit of the 13-bit unsigned angle word therefore switches its own sections on or off. There is no sign decision and no residual-angle arithmetic.

Vectors enter and leave on valid/ready streams. The 2-bit quadrant and domain tags pass through untouched, in step with their vector. The stage that produced the folded angle uses these tags afterwards to correct signs and scale.

Back-pressure is global to the pipeline:
- The pipeline advances on every cycle in which its output register is empty or is being taken.
- `in_ready` is high exactly in those cycles.
- While `out_valid` is high and `out_ready` is low, every stage holds. No vector is dropped or duplicated.

Data registers load only for valid entries. Bubbles leave them unchanged.

Top module: `rot_pipe`

## Requirements
- R1: A vector accepted on an input handshake appears at the output 12 clock edges later when nothing stalls. With `out_ready` held high, one vector is accepted every clock.
- R2: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_x`, `out_y`, `out_quad` and `out_dom` stay stable. Vectors leave in the order they were accepted, each exactly once.
- R3: Angle bit k, for k from 0 to 9, enables exactly one section, the one with shift index 14-k. A section that is not enabled passes its input through unchanged.
- R4: The six index-4 sections are enabled by bits 12, 11 and 10, which are worth four, two and one of those sections. A caller never sets all three bits at once.
- R5: An enabled section with index i computes x' = x - (x>>>(2i+1)) + (y>>>i) and y' = y - (y>>>(2i+1)) - (x>>>i). It uses truncating arithmetic right shifts on old values and wraps at 16 bits. For i of 8 or more, the (2i+1) terms are omitted.
- R6: Sections are applied in this order: the enabled index-4 sections first, then indices 5 to 14 in ascending order.
- R7: An angle word of zero returns the input vector bit-exact.
- R8: `out_quad` and `out_dom` equal the tags presented with the same vector.
- R9: After reset, `out_valid` is low and `in_ready` is high.
- R10: Angle 0x1657 (binary 1_011_001_010_111) applies section 4 five times, then sections 5, 8, 10, 12, 13 and 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input vector present |
| in_ready | output | 1 | Pipeline accepts an input this cycle |
| in_x | input | 16 | Input x, 14 fractional bits |
| in_y | input | 16 | Input y, 14 fractional bits |
| in_angle | input | 13 | Folded angle, unsigned, 14 fractional bits |
| in_quad | input | 2 | Quadrant tag, carried through |
| in_dom | input | 2 | Domain tag, carried through |
| out_valid | output | 1 | Output vector present |
| out_ready | input | 1 | Consumer takes the output this cycle |
| out_x | output | 16 | Rotated x |
| out_y | output | 16 | Rotated y |
| out_quad | output | 2 | Delayed quadrant tag |
| out_dom | output | 2 | Delayed domain tag |

## Verification
Suppose an enable bit is misaligned by one stage. The section is then driven by a neighbouring vector's angle, so results go wrong only for mixed angle streams. For that reason back-to-back vectors with unrelated angles are streamed. A wrong shift or a dropped second-order term changes low-order bits of the very first rotated vector, 12 cycles after it enters. A broken stall path shows up as an output that changes while held, or as a lost or repeated vector, in the first cycle of back-pressure.

// File: rtl/rot_pkg.sv
package rot_pkg;
  localparam int MIN_SHIFT = 4;
  localparam int MAX_SHIFT = 14;
  localparam int N_BASE    = 6;
  localparam int N_ONCE    = MAX_SHIFT - MIN_SHIFT;
  localparam int ENW       = N_BASE + N_ONCE;
  localparam int N_STAGE   = 12;
  localparam int FIRST_PAIR = 8;

  function automatic int stage_shift_a(input int s);
    if (s < N_BASE)          return MIN_SHIFT;
    else if (s < FIRST_PAIR) return MIN_SHIFT + 1 + (s - N_BASE);
    else                     return 7 + 2 * (s - FIRST_PAIR);
  endfunction

  function automatic bit stage_dual(input int s);
    return s >= FIRST_PAIR;
  endfunction

  function automatic int stage_shift_b(input int s);
    return stage_dual(s) ? stage_shift_a(s) + 1 : stage_shift_a(s);
  endfunction

  function automatic int en_slot(input int s, input int shift);
    if (shift == MIN_SHIFT) return s;
    else                    return shift + 1;
  endfunction
endpackage

// File: rtl/rot_section.sv
module rot_section #(
  parameter int W     = 16,
  parameter int SHIFT = 4
) (
  input  logic                en,
  input  logic signed [W-1:0] x_i,
  input  logic signed [W-1:0] y_i,
  output logic signed [W-1:0] x_o,
  output logic signed [W-1:0] y_o
);
  localparam int SQ_SHIFT = 2 * SHIFT + 1;
  logic signed [W-1:0] xr, yr;

  generate
    if (SHIFT < W / 2) begin : g_full
      always_comb begin
        xr = x_i - (x_i >>> SQ_SHIFT) + (y_i >>> SHIFT);
        yr = y_i - (y_i >>> SQ_SHIFT) - (x_i >>> SHIFT);
      end
    end else begin : g_lean
      always_comb begin
        xr = x_i + (y_i >>> SHIFT);
        yr = y_i - (x_i >>> SHIFT);
      end
    end
  endgenerate

  assign x_o = en ? xr : x_i;
  assign y_o = en ? yr : y_i;
endmodule

// File: rtl/rot_stage.sv
module rot_stage #(
  parameter int W    = 16,
  parameter int TW   = 2,
  parameter int ENW  = 16,
  parameter int SA   = 4,
  parameter int SB   = 4,
  parameter bit DUAL = 1'b0,
  parameter int EA   = 0,
  parameter int EB   = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv,
  input  logic                v_i,
  input  logic signed [W-1:0] x_i,
  input  logic signed [W-1:0] y_i,
  input  logic [TW-1:0]       quad_i,
  input  logic [TW-1:0]       dom_i,
  input  logic [ENW-1:0]      ena_i,
  output logic                v_o,
  output logic signed [W-1:0] x_o,
  output logic signed [W-1:0] y_o,
  output logic [TW-1:0]       quad_o,
  output logic [TW-1:0]       dom_o,
  output logic [ENW-1:0]      ena_o
);
  logic signed [W-1:0] xa, ya, xb, yb;
  logic [ENW-1:0] ena_left;

  rot_section #(.W(W), .SHIFT(SA)) u_sec_a (
    .en(ena_i[EA]), .x_i(x_i), .y_i(y_i), .x_o(xa), .y_o(ya)
  );

  generate
    if (DUAL) begin : g_pair
      rot_section #(.W(W), .SHIFT(SB)) u_sec_b (
        .en(ena_i[EB]), .x_i(xa), .y_i(ya), .x_o(xb), .y_o(yb)
      );
    end else begin : g_single
      assign xb = xa;
      assign yb = ya;
    end
  endgenerate

  always_comb begin
    ena_left     = ena_i;
    ena_left[EA] = 1'b0;
    ena_left[EB] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o    <= 1'b0;
      x_o    <= '0;
      y_o    <= '0;
      quad_o <= '0;
      dom_o  <= '0;
      ena_o  <= '0;
    end else if (adv) begin
      v_o <= v_i;
      if (v_i) begin
        x_o    <= xb;
        y_o    <= yb;
        quad_o <= quad_i;
        dom_o  <= dom_i;
        ena_o  <= ena_left;
      end
    end
  end

  // R1: valid moves one stage per advance
  a_r1_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> v_o == $past(v_i));

  // R2: a stalled stage keeps its contents
  a_r2_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(v_o) && $stable(x_o) && $stable(y_o));

  // R3 / R7: bypassed sections leave the vector untouched
  a_r3_bypass_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && v_i && !ena_i[EA] && !ena_i[EB]) |=>
      (x_o == $past(x_i)) && (y_o == $past(y_i)));

  // R8: tags travel with their vector
  a_r8_tag_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && v_i) |=> (quad_o == $past(quad_i)) && (dom_o == $past(dom_i)));
endmodule

// File: rtl/rot_pipe.sv
module rot_pipe #(
  parameter int W  = 16,
  parameter int AW = 13,
  parameter int TW = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic signed [W-1:0] in_x,
  input  logic signed [W-1:0] in_y,
  input  logic [AW-1:0]       in_angle,
  input  logic [TW-1:0]       in_quad,
  input  logic [TW-1:0]       in_dom,
  output logic                out_valid,
  input  logic                out_ready,
  output logic signed [W-1:0] out_x,
  output logic signed [W-1:0] out_y,
  output logic [TW-1:0]       out_quad,
  output logic [TW-1:0]       out_dom
);
  import rot_pkg::*;

  localparam int NS       = N_STAGE;
  localparam int ONCE_TOP = AW - 4;

  logic                adv;
  logic [ENW-1:0]      ena_in;
  logic [2:0]          base_cnt;

  logic                v_s    [0:NS];
  logic signed [W-1:0] x_s    [0:NS];
  logic signed [W-1:0] y_s    [0:NS];
  logic [TW-1:0]       quad_s [0:NS];
  logic [TW-1:0]       dom_s  [0:NS];
  logic [ENW-1:0]      ena_s  [0:NS];

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  // R4: weighted count of base sections from the three top angle bits
  assign base_cnt = {in_angle[AW-1], 2'b00} + {1'b0, in_angle[AW-2], 1'b0}
                  + {2'b00, in_angle[AW-3]};

  always_comb begin
    ena_in = '0;
    for (int j = 0; j < N_BASE; j++)
      ena_in[j] = (3'(j) < base_cnt);
    // R3: bit k drives the section of index MAX_SHIFT-k
    for (int k = 0; k <= ONCE_TOP; k++)
      ena_in[MAX_SHIFT - k + 1] = in_angle[k];
  end

  assign v_s[0]    = in_valid;
  assign x_s[0]    = in_x;
  assign y_s[0]    = in_y;
  assign quad_s[0] = in_quad;
  assign dom_s[0]  = in_dom;
  assign ena_s[0]  = ena_in;

  generate
    for (genvar s = 0; s < NS; s++) begin : g_stage
      localparam int SA = stage_shift_a(s);
      localparam int SB = stage_shift_b(s);
      rot_stage #(
        .W(W), .TW(TW), .ENW(ENW),
        .SA(SA), .SB(SB), .DUAL(stage_dual(s)),
        .EA(en_slot(s, SA)), .EB(en_slot(s, SB))
      ) u_stage (
        .clk(clk), .rst_n(rst_n), .adv(adv),
        .v_i(v_s[s]), .x_i(x_s[s]), .y_i(y_s[s]),
        .quad_i(quad_s[s]), .dom_i(dom_s[s]), .ena_i(ena_s[s]),
        .v_o(v_s[s+1]), .x_o(x_s[s+1]), .y_o(y_s[s+1]),
        .quad_o(quad_s[s+1]), .dom_o(dom_s[s+1]), .ena_o(ena_s[s+1])
      );
    end
  endgenerate

  assign out_valid = v_s[NS];
  assign out_x     = x_s[NS];
  assign out_y     = y_s[NS];
  assign out_quad  = quad_s[NS];
  assign out_dom   = dom_s[NS];

  // R2: a held output does not change
  a_r2_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_x) && $stable(out_y)
      && $stable(out_quad) && $stable(out_dom));

  // R3 / R6: every enable met its section exactly once on the way through
  a_r3_enables_spent: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ena_s[NS] == '0);

  // R4: caller rule on the three weighted bits
  a_r4_angle_legal: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> !(&in_angle[AW-1:AW-3]));

  // R9: nothing leaves in the first cycle out of reset
  a_r9_reset_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);
endmodule

// File: tb/rot_pipe_tb.sv
module rot_pipe_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid;
  logic signed [15:0] in_x = '0, in_y = '0, out_x, out_y;
  logic [12:0] in_angle = '0;
  logic [1:0] in_quad = '0, in_dom = '0, out_quad, out_dom;

  int checks = 0, fails = 0, cyc = 0;
  bit lat_mode = 1'b0;
  int ex[$], ey[$], et[$], ecyc[$];
  string ereq[$];
  logic hold_prev = 1'b0;
  logic signed [15:0] hx, hy;
  logic [3:0] ht;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rot_pipe dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_y(in_y), .in_angle(in_angle), .in_quad(in_quad),
    .in_dom(in_dom), .out_valid(out_valid), .out_ready(out_ready),
    .out_x(out_x), .out_y(out_y), .out_quad(out_quad), .out_dom(out_dom)
  );

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: run hung, actual running expected done");
    finish_run();
  end

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // R5: one enabled section
  function automatic void sec(inout logic signed [15:0] x, inout logic signed [15:0] y,
                              input int i);
    logic signed [15:0] nx, ny;
    nx = x + (y >>> i);
    ny = y - (x >>> i);
    if (i < 8) begin
      nx = nx - (x >>> (2*i+1));
      ny = ny - (y >>> (2*i+1));
    end
    x = nx;
    y = ny;
  endfunction

  // R4, R3, R6: behavioural angle decode and ordering
  function automatic void model(input logic signed [15:0] xi, input logic signed [15:0] yi,
                                input logic [12:0] a, output int xo, output int yo);
    logic signed [15:0] x, y;
    int n;
    x = xi; y = yi;
    n = 4*a[12] + 2*a[11] + a[10];
    for (int j = 0; j < n; j++) sec(x, y, 4);
    for (int k = 9; k >= 0; k--) if (a[k]) sec(x, y, 14 - k);
    xo = x; yo = y;
  endfunction

  task automatic step(input logic v, input logic signed [15:0] x, input logic signed [15:0] y,
                      input logic [12:0] a, input logic [3:0] tag, input logic rdy,
                      input string req);
    int mx, my;
    @(negedge clk);
    in_valid = v; in_x = x; in_y = y; in_angle = a;
    {in_quad, in_dom} = tag; out_ready = rdy;
    #1;
    if (hold_prev) begin
      check("R2 hold valid", out_valid, 1);
      check("R2 hold data", (out_x == hx) && (out_y == hy) && ({out_quad, out_dom} == ht), 1);
    end
    check("R2 ready rule", in_ready, (!out_valid || out_ready));
    if (out_valid && out_ready) begin
      if (ex.size() == 0) check("R2 unexpected output", 1, 0);
      else begin
        string r;
        int c;
        r = ereq.pop_front();
        c = ecyc.pop_front();
        check({r, " x"}, out_x, ex.pop_front());
        check({r, " y"}, out_y, ey.pop_front());
        check("R8 tags", {out_quad, out_dom}, et.pop_front());
        if (lat_mode) check("R1 latency", cyc - c, LAT);
      end
    end
    hold_prev = out_valid && !out_ready;
    hx = out_x; hy = out_y; ht = {out_quad, out_dom};
    if (in_valid && in_ready) begin
      model(x, y, a, mx, my);
      ex.push_back(mx); ey.push_back(my); et.push_back(tag);
      ecyc.push_back(cyc); ereq.push_back(req);
    end
  endtask

  function automatic logic [12:0] rnd_angle();
    return 13'($urandom % 6435);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R9 out_valid after reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 out_valid", out_valid, 0);
    check("R9 in_ready", in_ready, 1);

    lat_mode = 1'b1;
    step(1, 16'sd8192, 16'sd0, 13'h0000, 4'h9, 1, "R7 zero angle");
    step(1, -16'sd5000, 16'sd7000, 13'h1657, 4'h3, 1, "R10 example angle");
    step(1, 16'sd9000, -16'sd3000, 13'h1800, 4'h6, 1, "R4 six base sections");
    step(1, 16'sd4000, 16'sd4000, 13'h1922, 4'hC, 1, "R6 max angle");
    for (int k = 0; k < 13; k++)
      step(1, 16'sd10000, -16'sd2500, 13'(1 << k), 4'(k), 1, "R3 single bit");
    for (int i = 0; i < 40; i++)
      step(1, 16'($urandom % 20000) - 16'sd10000, 16'($urandom % 20000) - 16'sd10000,
           rnd_angle(), 4'($urandom), 1, "R1 back-to-back");
    repeat (LAT + 2) step(0, 0, 0, 0, 0, 1, "idle");
    lat_mode = 1'b0;

    for (int i = 0; i < 600; i++)
      step(1'($urandom % 4 != 0), 16'($urandom % 20000) - 16'sd10000,
           16'($urandom % 20000) - 16'sd10000, rnd_angle(), 4'($urandom),
           1'($urandom % 3 != 0), "R2 back-pressure");
    repeat (40) step(0, 0, 0, 0, 0, 1, "drain");
    check("R2 all vectors delivered", ex.size(), 0);
    finish_run();
  end
endmodule